// File: doc/BRIEF.md
# Eight-Channel 10-Bit ADC Control and Result Interface

This block is the register front end of a 10-bit analogue-to-digital converter with eight inputs. Software programs a control register with a conversion-clock select, a channel number and an enable bit, then sets a start bit. The start bit reads back as a busy indication for the length of the conversion and clears by itself when the result is ready. At that point a completion flag is raised, and it stays up until software clears it.

The converter itself is a synthesizable stand-in. At the start edge it captures the 10-bit sampled value of the selected channel. It then counts twelve bit times, each lasting 2, 8 or 32 input clocks depending on the clock select. A second register holds a justification bit and a stored port-configuration field. The 10-bit result appears across a high and a low result byte, either right- or left-justified, and the justification bit is applied when the result is read.

Top module: `adc_ctrl_if`

## Requirements
- R1: After reset, all four registers read 0x00 and `done_flag_o` is 0.
- R2: A write to address 0 with bit 0 (enable) and bit 2 (start) both 1, made while no conversion runs, starts a conversion. Bit 2 of address 0 reads 1 for exactly 12*D clock cycles from that write edge and then reads 0. D is 2, 8, 32 or 32 for bits 7:6 = 00, 01, 10, 11.
- R3: `done_flag_o` rises at the edge where a conversion completes and holds until an edge with `flag_clr_i` high. If completion and clear fall on the same edge, the flag is set.
- R4: With address 1 bit 7 at 1 (right-justified), address 2 reads {6'b0, r[9:8]} and address 3 reads r[7:0].
- R5: With address 1 bit 7 at 0 (left-justified), address 2 reads r[9:2] and address 3 reads {r[1:0], 6'b0}.
- R6: Address 1 stores bits 7 and 3:0, and bits 6:4 read 0. Address 0 stores bits 7:6, 5:3 and 0, and bit 1 reads 0. Writes to addresses 2 and 3 have no effect.
- R7: A start request written while bit 0 of the same write is 0 is ignored. Bit 2 stays 0 and no result or flag follows.
- R8: The result r is the value of `chan_data_i[10c+9:10c]` at the start edge, where c is address 0 bits 5:3 at that edge. The channel and clock select are latched at start, so later writes change neither the result nor the duration.
- R9: While a conversion runs, writing start again does not restart it, and writing 0 to bit 2 with bit 0 at 1 does not stop it.
- R10: Writing address 0 with bit 0 at 0 while a conversion runs aborts it. Busy reads 0 after that edge, no flag is raised and the result registers keep their old value.
- R11: Justification is applied at read time, so toggling address 1 bit 7 reformats the held result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address: 0 control, 1 config, 2 result high, 3 result low |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` (combinational) |
| flag_clr_i | input | 1 | Clears the completion flag |
| done_flag_o | output | 1 | Conversion-complete flag |
| chan_data_i | input | 80 | Sampled 10-bit values, channel c at bits 10c+9:10c |

## Verification
Conversions run with all four clock-select codes. Each run uses a different channel holding a distinct value, including all-ones and one with the MSB set. The busy bit is sampled one cycle before and one cycle after the expected end, so a wrong divider or an off-by-one in the bit count shows up. Each justification is read on values whose upper and lower bits differ, so swapped or shifted bytes stand out. Mid-conversion writes of a new channel, a repeated start and a disable separate latched from live control fields and abort from completion. A clear pulse on the completing edge checks that the flag set takes priority.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;
  localparam int unsigned REG_W     = 8;
  localparam int unsigned ADDR_W    = 2;
  localparam int unsigned NUM_CH    = 8;
  localparam int unsigned RES_W     = 10;
  localparam int unsigned CONV_BITS = 12;
  localparam int unsigned CKS_W     = 2;
  localparam int unsigned MAX_DIV   = 32;
  localparam int unsigned PCFG_W    = 4;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL   = 2'd0,
    REG_CFG    = 2'd1,
    REG_RES_HI = 2'd2,
    REG_RES_LO = 2'd3
  } reg_addr_e;

  // control register bit positions
  localparam int unsigned CTRL_EN_BIT  = 0;
  localparam int unsigned CTRL_GO_BIT  = 2;
  localparam int unsigned CTRL_CH_LSB  = 3;
  localparam int unsigned CTRL_CKS_LSB = 6;
  localparam int unsigned CFG_FMT_BIT  = 7;

  // input clocks per bit time
  function automatic int unsigned div_of(input logic [CKS_W-1:0] sel);
    case (sel)
      2'd0:    return 2;
      2'd1:    return 8;
      default: return 32;
    endcase
  endfunction
endpackage

// File: rtl/adc_bit_tick.sv
module adc_bit_tick
  import adc_ctrl_pkg::*;
#(
  parameter int unsigned SEL_W = CKS_W,
  parameter int unsigned DIV_MAX = MAX_DIV
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [SEL_W-1:0] cks_i,
  output logic             tick_o
);
  localparam int unsigned CNT_W = $clog2(DIV_MAX);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;

  always_comb lim = CNT_W'(div_of(cks_i) - 1);

  assign tick_o = run_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/adc_conv_unit.sv
module adc_conv_unit
  import adc_ctrl_pkg::*;
#(
  parameter int unsigned N_CH    = NUM_CH,
  parameter int unsigned DW      = RES_W,
  parameter int unsigned N_BITS  = CONV_BITS,
  parameter int unsigned SEL_W   = CKS_W,
  parameter int unsigned DIV_MAX = MAX_DIV
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic                    abort_i,
  input  logic [$clog2(N_CH)-1:0] chan_i,
  input  logic [SEL_W-1:0]        cks_i,
  input  logic [N_CH*DW-1:0]      data_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic [DW-1:0]           result_o
);
  localparam int unsigned BCNT_W = $clog2(N_BITS);
  localparam logic [BCNT_W-1:0] LAST_BIT = BCNT_W'(N_BITS - 1);

  logic [DW-1:0]     ch_val [N_CH];
  logic [SEL_W-1:0]  cks_q;
  logic [BCNT_W-1:0] bit_q;
  logic [DW-1:0]     sample_q;
  logic [DW-1:0]     result_q;
  logic              busy_q;
  logic              tick;

  for (genvar c = 0; c < N_CH; c++) begin : g_unpack
    assign ch_val[c] = data_i[c*DW +: DW];
  end

  adc_bit_tick #(
    .SEL_W  (SEL_W),
    .DIV_MAX(DIV_MAX)
  ) i_bit_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (busy_q),
    .cks_i (cks_q),
    .tick_o(tick)
  );

  assign done_o = busy_q && tick && (bit_q == LAST_BIT) && !abort_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      cks_q    <= '0;
      bit_q    <= '0;
      sample_q <= '0;
      result_q <= '0;
    end else if (abort_i) begin
      busy_q <= 1'b0;
    end else if (start_i) begin
      busy_q   <= 1'b1;
      cks_q    <= cks_i;
      bit_q    <= '0;
      sample_q <= ch_val[chan_i];
    end else if (busy_q && tick) begin
      if (bit_q == LAST_BIT) begin
        busy_q   <= 1'b0;
        result_q <= sample_q;
      end else begin
        bit_q <= bit_q + 1'b1;
      end
    end
  end

  assign busy_o   = busy_q;
  assign result_o = result_q;
endmodule

// File: rtl/adc_res_pack.sv
module adc_res_pack
  import adc_ctrl_pkg::*;
#(
  parameter int unsigned DW = RES_W,
  parameter int unsigned BW = REG_W
) (
  input  logic [DW-1:0] res_i,
  input  logic          right_i,
  output logic [BW-1:0] hi_o,
  output logic [BW-1:0] lo_o
);
  localparam int unsigned PAD = 2*BW - DW;

  logic [2*BW-1:0] word_r;
  logic [2*BW-1:0] word_l;
  logic [2*BW-1:0] word;

  assign word_r = {{PAD{1'b0}}, res_i};
  assign word_l = {res_i, {PAD{1'b0}}};
  assign word   = right_i ? word_r : word_l;
  assign hi_o   = word[2*BW-1:BW];
  assign lo_o   = word[BW-1:0];
endmodule

// File: rtl/adc_ctrl_if.sv
module adc_ctrl_if
  import adc_ctrl_pkg::*;
#(
  parameter int unsigned N_CH    = NUM_CH,
  parameter int unsigned DW      = RES_W,
  parameter int unsigned N_BITS  = CONV_BITS,
  parameter int unsigned DIV_MAX = MAX_DIV
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [REG_W-1:0]   wdata_i,
  output logic [REG_W-1:0]   rdata_o,
  input  logic               flag_clr_i,
  output logic               done_flag_o,
  input  logic [N_CH*DW-1:0] chan_data_i
);
  localparam int unsigned CH_W = $clog2(N_CH);

  logic [CKS_W-1:0]  cks_q;
  logic [CH_W-1:0]   chan_q;
  logic              en_q;
  logic              fmt_q;
  logic [PCFG_W-1:0] pcfg_q;
  logic              flag_q;
  logic              busy;
  logic              done;
  logic [DW-1:0]     res;
  logic [REG_W-1:0]  res_hi;
  logic [REG_W-1:0]  res_lo;
  logic              wr_ctrl;
  logic              wr_cfg;
  logic              start;
  logic              abort;

  assign wr_ctrl = wr_en_i && (addr_i == REG_CTRL);
  assign wr_cfg  = wr_en_i && (addr_i == REG_CFG);
  assign start   = wr_ctrl && wdata_i[CTRL_GO_BIT] && wdata_i[CTRL_EN_BIT] && !busy;
  assign abort   = wr_ctrl && !wdata_i[CTRL_EN_BIT] && busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cks_q  <= '0;
      chan_q <= '0;
      en_q   <= 1'b0;
    end else if (wr_ctrl) begin
      cks_q  <= wdata_i[CTRL_CKS_LSB +: CKS_W];
      chan_q <= wdata_i[CTRL_CH_LSB +: CH_W];
      en_q   <= wdata_i[CTRL_EN_BIT];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fmt_q  <= 1'b0;
      pcfg_q <= '0;
    end else if (wr_cfg) begin
      fmt_q  <= wdata_i[CFG_FMT_BIT];
      pcfg_q <= wdata_i[PCFG_W-1:0];
    end
  end

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         flag_q <= 1'b0;
    else if (done)       flag_q <= 1'b1;
    else if (flag_clr_i) flag_q <= 1'b0;
  end

  adc_conv_unit #(
    .N_CH   (N_CH),
    .DW     (DW),
    .N_BITS (N_BITS),
    .SEL_W  (CKS_W),
    .DIV_MAX(DIV_MAX)
  ) i_conv (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .abort_i (abort),
    .chan_i  (wdata_i[CTRL_CH_LSB +: CH_W]),
    .cks_i   (wdata_i[CTRL_CKS_LSB +: CKS_W]),
    .data_i  (chan_data_i),
    .busy_o  (busy),
    .done_o  (done),
    .result_o(res)
  );

  adc_res_pack #(
    .DW(DW),
    .BW(REG_W)
  ) i_pack (
    .res_i  (res),
    .right_i(fmt_q),
    .hi_o   (res_hi),
    .lo_o   (res_lo)
  );

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      REG_CTRL: begin
        rdata_o[CTRL_CKS_LSB +: CKS_W] = cks_q;
        rdata_o[CTRL_CH_LSB +: CH_W]   = chan_q;
        rdata_o[CTRL_GO_BIT]           = busy;
        rdata_o[CTRL_EN_BIT]           = en_q;
      end
      REG_CFG: begin
        rdata_o[CFG_FMT_BIT]  = fmt_q;
        rdata_o[PCFG_W-1:0]   = pcfg_q;
      end
      REG_RES_HI: rdata_o = res_hi;
      default:    rdata_o = res_lo;
    endcase
  end

  assign done_flag_o = flag_q;
endmodule

// File: rtl/adc_ctrl_chk.sv
module adc_ctrl_chk
  import adc_ctrl_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [REG_W-1:0]  wdata_i,
  input logic [REG_W-1:0]  rdata_o,
  input logic              done_flag_o,
  input logic              busy_i,
  input logic              fmt_i
);
  logic [15:0] run_cnt_q;
  logic [15:0] run_exp_q;
  logic        wr_ctrl;

  assign wr_ctrl = wr_en_i && (addr_i == REG_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_cnt_q <= '0;
      run_exp_q <= '0;
    end else if (wr_ctrl && wdata_i[CTRL_GO_BIT] && wdata_i[CTRL_EN_BIT] && !busy_i) begin
      run_cnt_q <= '0;
      run_exp_q <= 16'(CONV_BITS * div_of(wdata_i[CTRL_CKS_LSB +: CKS_W]));
    end else if (busy_i) begin
      run_cnt_q <= run_cnt_q + 1'b1;
    end
  end

  // R2
  conv_length_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_flag_o) |-> run_cnt_q == run_exp_q);

  // R3
  flag_after_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_flag_o) |-> $past(busy_i));

  // R7
  start_off_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctrl && !wdata_i[CTRL_EN_BIT] && !busy_i) |=> !busy_i);

  // R10
  abort_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctrl && !wdata_i[CTRL_EN_BIT] && busy_i) |=> !busy_i && !$rose(done_flag_o));

  // R6
  cfg_reserved_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == REG_CFG) |-> rdata_o[6:4] == 3'b000);

  // R6
  ctrl_reserved_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == REG_CTRL) |-> !rdata_o[1]);

  // R4
  right_hi_pad_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == REG_RES_HI && fmt_i) |-> rdata_o[7:2] == 6'd0);

  // R5
  left_lo_pad_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == REG_RES_LO && !fmt_i) |-> rdata_o[5:0] == 6'd0);
endmodule

bind adc_ctrl_if adc_ctrl_chk i_adc_ctrl_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .done_flag_o(done_flag_o),
  .busy_i     (busy),
  .fmt_i      (fmt_q)
);

// File: tb/test_adc_ctrl_if.sv
module test_adc_ctrl_if;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  addr_i = 2'd0;
  logic [7:0]  wdata_i = 8'd0;
  logic [7:0]  rdata_o;
  logic        flag_clr_i = 1'b0;
  logic        done_flag_o;
  logic [79:0] chan_data_i = '0;

  int checks = 0;
  int errors = 0;

  logic [9:0] ch_val [8] = '{10'h201, 10'h155, 10'h0AA, 10'h3C7,
                             10'h000, 10'h2E5, 10'h07E, 10'h3FF};

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  adc_ctrl_if i_adc_ctrl_if (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .flag_clr_i (flag_clr_i),
    .done_flag_o(done_flag_o),
    .chan_data_i(chan_data_i)
  );

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // entered and left at a falling edge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr_i = a;
    #1;
    d = rdata_o;
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic clr_flag();
    flag_clr_i = 1'b1;
    @(negedge clk_i);
    flag_clr_i = 1'b0;
  endtask

  function automatic int div_of(input logic [1:0] s);
    return (s == 2'd0) ? 2 : (s == 2'd1) ? 8 : 32;
  endfunction

  function automatic logic [7:0] ctrl_word(input logic [1:0] cks, input logic [2:0] ch,
                                           input logic go, input logic en);
    return {cks, ch, go, 1'b0, en};
  endfunction

  task automatic chk_result(input string req, input logic fmt, input logic [9:0] r);
    logic [7:0] hi, lo;
    rd(2'd2, hi);
    rd(2'd3, lo);
    if (fmt) begin
      chk({req, " right hi"}, {8'h0, hi}, {8'h0, 6'b0, r[9:8]});
      chk({req, " right lo"}, {8'h0, lo}, {8'h0, r[7:0]});
    end else begin
      chk({req, " left hi"}, {8'h0, hi}, {8'h0, r[9:2]});
      chk({req, " left lo"}, {8'h0, lo}, {8'h0, r[1:0], 6'b0});
    end
  endtask

  task automatic t_reset();
    logic [7:0] d;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      chk("R1 reg reset", {8'h0, d}, 16'h0);
    end
    chk("R1 flag reset", {15'h0, done_flag_o}, 16'h0);
  endtask

  task automatic t_fields();
    logic [7:0] d;
    wr(2'd1, 8'hFF);
    rd(2'd1, d);
    chk("R6 cfg bits", {8'h0, d}, 16'h008F);
    wr(2'd0, 8'hC2);
    rd(2'd0, d);
    chk("R6 ctrl bit1", {8'h0, d}, 16'h00C0);
    wr(2'd2, 8'hAA);
    wr(2'd3, 8'h55);
    rd(2'd2, d);
    chk("R6 res hi read-only", {8'h0, d}, 16'h0);
    rd(2'd3, d);
    chk("R6 res lo read-only", {8'h0, d}, 16'h0);
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_start_off();
    logic [7:0] d;
    wr(2'd0, ctrl_word(2'd0, 3'd7, 1'b1, 1'b0));
    rd(2'd0, d);
    chk("R7 start while off", {15'h0, d[2]}, 16'h0);
    wait_n(40);
    chk("R7 no flag", {15'h0, done_flag_o}, 16'h0);
    rd(2'd2, d);
    chk("R7 no result", {8'h0, d}, 16'h0);
  endtask

  task automatic t_convert(input logic [1:0] cks, input logic [2:0] ch, input logic fmt);
    logic [7:0] d;
    int n;
    n = 12 * div_of(cks);
    wr(2'd1, {fmt, 7'h0});
    clr_flag();
    wr(2'd0, ctrl_word(cks, ch, 1'b1, 1'b1));
    rd(2'd0, d);
    chk("R2 busy after start", {15'h0, d[2]}, 16'h1);
    wait_n(n - 1);
    rd(2'd0, d);
    chk("R2 busy at last cycle", {15'h0, d[2]}, 16'h1);
    chk("R3 flag low before end", {15'h0, done_flag_o}, 16'h0);
    wait_n(1);
    rd(2'd0, d);
    chk("R2 busy cleared", {15'h0, d[2]}, 16'h0);
    chk("R3 flag set", {15'h0, done_flag_o}, 16'h1);
    chk_result(fmt ? "R4 R8" : "R5 R8", fmt, ch_val[ch]);
    wait_n(5);
    chk("R3 flag held", {15'h0, done_flag_o}, 16'h1);
    clr_flag();
    chk("R3 flag cleared", {15'h0, done_flag_o}, 16'h0);
  endtask

  task automatic t_chan_change();
    logic [7:0] d;
    wr(2'd1, 8'h80);
    wr(2'd0, ctrl_word(2'd0, 3'd1, 1'b1, 1'b1));
    wait_n(4);
    wr(2'd0, ctrl_word(2'd2, 3'd6, 1'b0, 1'b1));
    wait_n(24 - 1 - 5);
    rd(2'd0, d);
    chk("R8 R9 still busy", {15'h0, d[2]}, 16'h1);
    wait_n(1);
    rd(2'd0, d);
    chk("R8 duration kept", {15'h0, d[2]}, 16'h0);
    chk_result("R8 channel latched", 1'b1, ch_val[1]);
    clr_flag();
  endtask

  task automatic t_restart();
    logic [7:0] d;
    wr(2'd1, 8'h00);
    wr(2'd0, ctrl_word(2'd1, 3'd2, 1'b1, 1'b1));
    wait_n(9);
    wr(2'd0, ctrl_word(2'd0, 3'd4, 1'b1, 1'b1));
    wait_n(96 - 1 - 10);
    rd(2'd0, d);
    chk("R9 no restart busy", {15'h0, d[2]}, 16'h1);
    wait_n(1);
    rd(2'd0, d);
    chk("R9 original end", {15'h0, d[2]}, 16'h0);
    chk("R9 flag", {15'h0, done_flag_o}, 16'h1);
    chk_result("R9 result", 1'b0, ch_val[2]);
    clr_flag();
  endtask

  task automatic t_abort();
    logic [7:0] d;
    wr(2'd0, ctrl_word(2'd0, 3'd7, 1'b1, 1'b1));
    wait_n(3);
    wr(2'd0, 8'h00);
    rd(2'd0, d);
    chk("R10 abort busy", {15'h0, d[2]}, 16'h0);
    wait_n(30);
    chk("R10 no flag", {15'h0, done_flag_o}, 16'h0);
    chk_result("R10 result kept", 1'b0, ch_val[2]);
  endtask

  task automatic t_fmt_reread();
    wr(2'd1, 8'h80);
    chk_result("R11 to right", 1'b1, ch_val[2]);
    wr(2'd1, 8'h00);
    chk_result("R11 to left", 1'b0, ch_val[2]);
  endtask

  task automatic t_flag_collide();
    wr(2'd0, ctrl_word(2'd0, 3'd3, 1'b1, 1'b1));
    wait_n(23);
    flag_clr_i = 1'b1;
    wait_n(1);
    flag_clr_i = 1'b0;
    chk("R3 set beats clear", {15'h0, done_flag_o}, 16'h1);
    clr_flag();
    chk("R3 cleared after", {15'h0, done_flag_o}, 16'h0);
  endtask

  initial begin
    for (int c = 0; c < 8; c++) chan_data_i[c*10 +: 10] = ch_val[c];
    wait_n(3);
    rst_ni = 1'b1;
    wait_n(1);
    t_reset();
    t_fields();
    t_start_off();
    t_convert(2'd0, 3'd7, 1'b1);
    t_convert(2'd1, 3'd0, 1'b0);
    t_convert(2'd2, 3'd3, 1'b1);
    t_convert(2'd3, 3'd5, 1'b0);
    t_chan_change();
    t_restart();
    t_abort();
    t_fmt_reread();
    t_flag_collide();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule